// File: doc/BRIEF.md
# I2C SCL Clock-Period Generator

This block produces the SCL clock for an I2C master from the system clock. Software sets a power-of-two prescaler and two 5-bit counts, one for the low phase and one for the high phase. The block adds a fixed number of prescaled cycles to each count to cover the input synchroniser and the noise filter. The block pulls SCL low for the low phase and then releases it. The high phase is timed only after the filtered SCL input reads high. As a result, a slow rising edge, or another master holding the line low, stretches the clock rather than shortening the high time.

For the byte engine, the block emits two single-cycle pulses. A change pulse marks the middle of each low phase, where SDA may change. A sample pulse marks the middle of each high phase, where SDA is sampled. The block also provides filtered copies of SCL and SDA. The drive-strength request for the faster bus mode passes through the block unchanged. There is no streaming interface. All pins are plain control, configuration and status signals.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescaler select is the 3-bit field n in bits 6:4 of the mode register (select 0). One prescaled unit lasts 2^n system clocks, and the SCL low phase lasts exactly T_L·2^n clocks.
- R2: Each phase target is the programmed count plus an overhead: 4 units when n = 0 and 3 units when n > 0. That is, T_L = low count + overhead and T_H = high count + overhead.
- R3: A programmed count of 0 behaves exactly like a count of 1.
- R4: A write to the mode register changes n only if bit 3 of that same write is 1. Otherwise n keeps its value. The mode register reads back as {0, n, 0000}.
- R5: The low-count register (select 1) and the high-count register (select 2) store bits 4:0 of the write data. Both read back with bits 7:5 set to 1. Select 3 reads back as 0.
- R6: The high phase starts when the block releases SCL. Its T_H·2^n clocks are counted only once the filtered SCL reads high. With an immediate rise, the high phase lasts 2 + T_H·2^n clocks. If the line is held low externally, the low time on the line grows by the hold time.
- R7: SCL and SDA inputs pass through a filter that takes a new level only after two consecutive clock samples agree. A one-clock glitch never reaches the filtered output.
- R8: The change pulse fires once per low phase, (T_L>>1)·2^n clocks after SCL starts to be driven low.
- R9: The sample pulse fires once per high phase, (T_H>>1)·2^n clocks after the filtered SCL first reads high.
- R10: While the enable is low or the hold is high, SCL is released from the next clock onward and neither pulse fires. When the block is re-enabled, it starts a fresh low phase.
- R11: The fast-mode drive output always equals the fast-mode enable input.
- R12: After reset, n is 0 and both counts are 0. SCL is released, no pulse fires, and the filtered lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL generator |
| hold | input | 1 | Byte engine request to stop toggling SCL |
| fmp_en | input | 1 | Fast-mode drive request |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 low count, 2 high count |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_filt | output | 1 | Filtered SCL level |
| sda_filt | output | 1 | Filtered SDA level |
| chg_tick | output | 1 | Mid-low pulse: SDA may change |
| smp_tick | output | 1 | Mid-high pulse: SDA is sampled |
| fmp_drive | output | 1 | Drive-strength request to the pads |

## Verification
Some behaviours are checked by assertions on every cycle. SCL is released the clock after the enable drops or the hold rises. A change pulse appears only while SCL is driven low, and a sample pulse only while SCL is released and its filtered level is high. The filtered SDA takes a new level only after the raw input held that level on the previous edge. A mode write without the protect bit leaves the prescaler untouched, and the count registers always read back with their reserved bits set. Other behaviours need the bench's scenarios. These are the exact phase widths and pulse positions for every prescaler and a range of counts, including zero. They also include the per-prescaler overhead, the stretch when SCL is held low by another driver, and the restart after a hold.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic smp_q;
    logic lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b1;
        lvl_q <= 1'b1;
      end else begin
        smp_q <= raw[i];
        if (smp_q == raw[i]) lvl_q <= raw[i];
      end
    end
    assign filt[i] = lvl_q;
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              unit_tick,
  output logic              unit_first
);
  localparam int PC_W = (1 << PSEL_W) - 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W:0]   lim_w;
  logic [PC_W-1:0] lim;

  assign lim_w      = ((PC_W+1)'(1) << psel) - (PC_W+1)'(1);
  assign lim        = lim_w[PC_W-1:0];
  assign unit_tick  = (pcnt >= lim);
  assign unit_first = (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (clear)   pcnt <= '0;
    else if (run)     pcnt <= unit_tick ? '0 : pcnt + PC_W'(1);
  end
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs import scl_gen_pkg::*; #(
  parameter int PSEL_W = 3,
  parameter int CNT_W  = 5,
  parameter int OVH0   = 4,
  parameter int OVHN   = 3,
  parameter int T_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [PSEL_W-1:0] psel,
  output logic [T_W-1:0]    t_low,
  output logic [T_W-1:0]    t_high
);
  localparam int MODE_LSB = 4;
  localparam int WP_BIT   = 3;
  localparam int RSV_W    = 8 - CNT_W;

  logic [CNT_W-1:0] lo_q, hi_q;
  logic [T_W-1:0]   ovh;
  logic             unused_wbits;

  assign unused_wbits = wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_MODE: if (wdata[WP_BIT]) psel <= wdata[MODE_LSB +: PSEL_W];
        SEL_LOW:  lo_q <= wdata[CNT_W-1:0];
        SEL_HIGH: hi_q <= wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE: rdata = 8'({psel, 4'b0000});
      SEL_LOW:  rdata = {{RSV_W{1'b1}}, lo_q};
      SEL_HIGH: rdata = {{RSV_W{1'b1}}, hi_q};
      default:  rdata = '0;
    endcase
  end

  assign ovh    = (psel == '0) ? T_W'(OVH0) : T_W'(OVHN);
  assign t_low  = ((lo_q == '0) ? T_W'(1) : T_W'(lo_q)) + ovh;
  assign t_high = ((hi_q == '0) ? T_W'(1) : T_W'(hi_q)) + ovh;
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl import scl_gen_pkg::*; #(
  parameter int T_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           unit_tick,
  input  logic           unit_first,
  input  logic           scl_f,
  input  logic [T_W-1:0] t_low,
  input  logic [T_W-1:0] t_high,
  output phase_t         phase,
  output logic           pre_run,
  output logic           pre_clear,
  output logic           chg_tick,
  output logic           smp_tick
);
  logic [T_W-1:0] cnt;
  logic [T_W-1:0] tgt;
  logic           hi_run;
  logic           hi_live;
  logic           unit_end;
  logic           last;

  assign hi_live   = (phase == PH_HIGH) && (hi_run || scl_f);
  assign pre_run   = (phase == PH_LOW) || hi_live;
  assign pre_clear = !go || (phase == PH_IDLE);
  assign unit_end  = pre_run && unit_tick;
  assign tgt       = (phase == PH_HIGH) ? t_high : t_low;
  assign last      = (cnt == tgt - T_W'(1));
  assign chg_tick  = (phase == PH_LOW) && unit_first && (cnt == (t_low >> 1));
  assign smp_tick  = hi_live && unit_first && (cnt == (t_high >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      hi_run <= 1'b0;
    end else if (!go) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      hi_run <= 1'b0;
    end else if (phase == PH_IDLE) begin
      phase <= PH_LOW;
      cnt   <= '0;
    end else begin
      if (hi_live) hi_run <= 1'b1;
      if (unit_end) begin
        if (last) begin
          phase  <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
          cnt    <= '0;
          hi_run <= 1'b0;
        end else begin
          cnt <= cnt + T_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen import scl_gen_pkg::*; #(
  parameter int PSEL_W = 3,
  parameter int CNT_W  = 5,
  parameter int OVH0   = 4,
  parameter int OVHN   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       hold,
  input  logic       fmp_en,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       scl_filt,
  output logic       sda_filt,
  output logic       chg_tick,
  output logic       smp_tick,
  output logic       fmp_drive
);
  localparam int T_W = $clog2((1 << CNT_W) + OVH0);

  logic [PSEL_W-1:0] psel;
  logic [T_W-1:0]    t_low, t_high;
  logic              unit_tick, unit_first, pre_run, pre_clear;
  phase_t            phase;

  scl_cfg_regs #(.PSEL_W(PSEL_W), .CNT_W(CNT_W), .OVH0(OVH0), .OVHN(OVHN), .T_W(T_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .psel(psel), .t_low(t_low), .t_high(t_high)
  );

  scl_line_filter #(.W(2)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw({sda_in, scl_in}), .filt({sda_filt, scl_filt})
  );

  scl_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(pre_clear), .run(pre_run), .psel(psel),
    .unit_tick(unit_tick), .unit_first(unit_first)
  );

  scl_phase_ctrl #(.T_W(T_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .go(enable && !hold), .unit_tick(unit_tick),
    .unit_first(unit_first), .scl_f(scl_filt), .t_low(t_low), .t_high(t_high),
    .phase(phase), .pre_run(pre_run), .pre_clear(pre_clear),
    .chg_tick(chg_tick), .smp_tick(smp_tick)
  );

  assign scl_drive_low = (phase == PH_LOW);
  assign fmp_drive     = fmp_en;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int PSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              hold,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic              reg_wp,
  input logic [2:0]        rd_top,
  input logic              sda_in,
  input logic              sda_filt,
  input logic              scl_filt,
  input logic              scl_drive_low,
  input logic              chg_tick,
  input logic              smp_tick,
  input logic [PSEL_W-1:0] psel_q
);
  p_off_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || hold) |=> !scl_drive_low);

  p_chg_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_tick |-> scl_drive_low);

  p_smp_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |-> (!scl_drive_low && scl_filt));

  p_sda_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_filt != $past(sda_filt)) |-> ($past(sda_in) == sda_filt));

  p_mode_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0 && !reg_wp) |=> (psel_q == $past(psel_q)));

  p_reserved_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd1 || reg_sel == 2'd2) |-> (rd_top == 3'b111));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.PSEL_W(PSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wp(reg_wdata[3]), .rd_top(reg_rdata[7:5]),
  .sda_in(sda_in), .sda_filt(sda_filt), .scl_filt(scl_filt),
  .scl_drive_low(scl_drive_low), .chg_tick(chg_tick), .smp_tick(smp_tick),
  .psel_q(psel)
);

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, hold = 1'b0, fmp_en = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sda_in = 1'b1, ext_low = 1'b0;
  logic       scl_line, scl_drive_low, scl_filt, sda_filt, chg_tick, smp_tick, fmp_drive;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign scl_line = ~(scl_drive_low | ext_low);

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold), .fmp_en(fmp_en),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_in(scl_line), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .scl_filt(scl_filt), .sda_filt(sda_filt), .chg_tick(chg_tick),
    .smp_tick(smp_tick), .fmp_drive(fmp_drive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    @(negedge clk);
    reg_sel = s;
    #1 v = int'(reg_rdata);
  endtask

  task automatic measure(output int lw, output int hw, output int ci, output int si);
    @(negedge clk);
    while (scl_line !== 1'b1) @(negedge clk);
    while (scl_line === 1'b1) @(negedge clk);
    lw = 0; ci = -1;
    while (scl_line === 1'b0) begin
      if (chg_tick && ci < 0) ci = lw;
      lw++;
      @(negedge clk);
    end
    hw = 0; si = -1;
    while (scl_line === 1'b1) begin
      if (smp_tick && si < 0) si = hw;
      hw++;
      @(negedge clk);
    end
  endtask

  task automatic run_combo(input int n, input int lo, input int hi);
    int lw, hw, ci, si, tl, th, ov;
    @(negedge clk) enable = 1'b0;
    wr(2'd0, 8'((n << 4) | 8));
    wr(2'd1, 8'(lo));
    wr(2'd2, 8'(hi));
    @(negedge clk) enable = 1'b1;
    measure(lw, hw, ci, si);
    enable = 1'b0;
    ov = (n == 0) ? 4 : 3;
    tl = ((lo == 0) ? 1 : lo) + ov;
    th = ((hi == 0) ? 1 : hi) + ov;
    check(lw == (tl << n), (lo == 0) ? "R3 low width zero count" : "R1 R2 low width", lw, tl << n);
    check(hw == 2 + (th << n), (hi == 0) ? "R3 high width zero count" : "R6 R2 high width", hw, 2 + (th << n));
    check(ci == ((tl >> 1) << n), "R8 change pulse position", ci, (tl >> 1) << n);
    check(si == 2 + ((th >> 1) << n), "R9 sample pulse position", si, 2 + ((th >> 1) << n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired: act=200000 exp=<200000");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, bad, w, rel, hw, si;
    int vals[5] = '{0, 1, 2, 7, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(2'd0, v); check(v == 0, "R12 mode after reset", v, 0);
    rd(2'd1, v); check(v == 8'hE0, "R12 low count after reset", v, 8'hE0);
    rd(2'd2, v); check(v == 8'hE0, "R12 high count after reset", v, 8'hE0);
    check(!scl_drive_low && !chg_tick && !smp_tick && scl_filt && sda_filt,
          "R12 outputs idle after reset", scl_drive_low, 0);
    // R11 pass-through
    fmp_en = 1'b1; #1 check(fmp_drive == 1'b1, "R11 drive follows enable high", fmp_drive, 1);
    fmp_en = 1'b0; #1 check(fmp_drive == 1'b0, "R11 drive follows enable low", fmp_drive, 0);
    // R5 read-back of count registers
    wr(2'd1, 8'h1F); rd(2'd1, v); check(v == 8'hFF, "R5 low count max", v, 8'hFF);
    wr(2'd2, 8'hA5); rd(2'd2, v); check(v == 8'hE5, "R5 high count upper bits", v, 8'hE5);
    rd(2'd3, v); check(v == 0, "R5 unused select", v, 0);
    // R4 write protect on the prescaler field
    wr(2'd0, 8'h28); rd(2'd0, v); check(v == 8'h20, "R4 protected write accepted", v, 8'h20);
    wr(2'd0, 8'h50); rd(2'd0, v); check(v == 8'h20, "R4 write without protect bit ignored", v, 8'h20);
    wr(2'd0, 8'h58); rd(2'd0, v); check(v == 8'h50, "R4 second protected write", v, 8'h50);
    // R7 glitch filtering on SDA
    @(negedge clk) sda_in = 1'b0;
    @(negedge clk) sda_in = 1'b1;
    bad = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (!sda_filt) bad++; end
    check(bad == 0, "R7 one-clock glitch rejected", bad, 0);
    @(negedge clk) sda_in = 1'b0;
    repeat (3) @(negedge clk);
    check(sda_filt == 1'b0, "R7 steady low accepted", sda_filt, 0);
    sda_in = 1'b1;
    repeat (3) @(negedge clk);
    check(sda_filt == 1'b1, "R7 steady high accepted", sda_filt, 1);
    // R1 R2 R3 R6 R8 R9 sweep of counts at n = 0
    foreach (vals[a]) foreach (vals[b]) run_combo(0, vals[a], vals[b]);
    // R1 R2 sweep of every prescaler setting
    for (int n = 1; n < 8; n++) run_combo(n, 2, 9);
    // R6 external hold stretches the clock: n=1, T_L=5, T_H=6
    @(negedge clk) enable = 1'b0;
    wr(2'd0, 8'h18); wr(2'd1, 8'd2); wr(2'd2, 8'd3);
    @(negedge clk) enable = 1'b1;
    while (scl_line !== 1'b0) @(negedge clk);
    ext_low = 1'b1;
    w = 0; rel = 0;
    while (scl_line === 1'b0) begin
      if (!scl_drive_low) rel++;
      w++;
      if (rel == 7) ext_low = 1'b0;
      @(negedge clk);
    end
    check(w == 17, "R6 stretched low width", w, 17);
    hw = 0; si = -1;
    while (scl_line === 1'b1) begin
      if (smp_tick && si < 0) si = hw;
      hw++;
      @(negedge clk);
    end
    check(hw == 13, "R6 high width after stretch", hw, 13);
    check(si == 7, "R9 sample pulse after stretch", si, 7);
    // R10 hold and disable release the line
    repeat (3) @(negedge clk);
    hold = 1'b1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (scl_drive_low || chg_tick || smp_tick) bad++;
    end
    check(bad == 0, "R10 quiet while held", bad, 0);
    hold = 1'b0;
    begin
      int lw, hw2, ci, si2;
      measure(lw, hw2, ci, si2);
      check(lw == 10, "R10 fresh low phase after hold", lw, 10);
    end
    enable = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_drive_low || chg_tick || smp_tick) bad++;
    end
    check(bad == 0, "R10 quiet while disabled", bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule